// File: doc/BRIEF.md
# SPI Byte Master

This block is the master side of a serial peripheral link. It moves one byte per transfer in any of the four clock-polarity and clock-phase combinations. A host writes the byte to send into a transmit holding register and reads the received byte from a receive holding register. A combined control and status register carries four configuration bits and four flags for handshaking.

The serial bit clock is the block clock divided by two. Each clock cycle is one half of a bit period, so the serial clock has a 50% duty cycle whatever the duty cycle of the source. The serial clock leaves the block only while a byte is on the wire and otherwise rests at its idle level. Incoming serial data is caught in a one-bit capture register on the sampling edge. It enters the shift register half a bit period later, on the shifting edge. The block does not drive any slave-select line.

A single interrupt output is driven by one of two selectable sources: the transmit holding register being empty, or the completion flag. The completion flag is cleared by reading the control/status register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control/status register reads 0x10, `sclk` is low, `mosi` is high and, with `irq_on_done` low, `irq` is high.
- R2: While idle, `sclk` rests at the polarity bit (control bit 1). A transfer lasts 2*DATA_W clock cycles, and `sclk` changes level on every one of them. In the first half of a transfer, `sclk` equals polarity XOR phase (phase is control bit 2).
- R3: `mosi` is high while no transfer is in flight. During every even-numbered half of a transfer, `mosi` holds the data bit of that bit slot, so the bit is stable at the sampling edge in all four modes.
- R4: With control bit 3 clear, the byte goes out most significant bit first. With control bit 3 set, it goes out least significant bit first. The received byte is assembled in the same order.
- R5: `miso` is sampled on the clock edge that ends each even-numbered half and is held for one half before it is shifted in. After the transfer the received byte reads back from address 1. A value on `miso` during the odd halves has no effect.
- R6: A write to address 0 is accepted while the transmit register is empty. If the block is enabled and idle, the transfer starts one clock later. A byte written during a transfer starts right after it, with no idle half between the two. A write while the transmit register is full is dropped.
- R7: The RX-full flag (status bit 5) sets when a transfer completes and clears when address 1 is read.
- R8: The done flag (status bit 6) sets when a transfer completes and clears when address 2 is read.
- R9: With `irq_on_done` low, `irq` follows "transmit register empty". With `irq_on_done` high, `irq` follows the done flag.
- R10: While the enable bit (control bit 0) is clear, no transfer starts and a written byte stays pending. Setting the bit starts it.
- R11: Address 2 reads the configuration in bits 3..0, TX-empty in bit 4, RX-full in bit 5, done in bit 6 and busy in bit 7. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one cycle is half a bit period |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register address: 0 transmit, 1 receive, 2 control/status |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | DATA_W | Write data |
| host_rd | input | 1 | Read strobe; triggers read side effects |
| host_rdata | output | DATA_W | Read data for the addressed register |
| irq_on_done | input | 1 | Interrupt source select: 0 TX empty, 1 done |
| miso | input | 1 | Serial data from the slave |
| mosi | output | 1 | Serial data to the slave |
| sclk | output | 1 | Gated serial clock |
| irq | output | 1 | Block interrupt |

## Verification
On every cycle, the assertions hold the idle levels of `sclk` and `mosi` and the toggling of `sclk` inside a byte. They also check that a transfer begins only from an enabled, full transmit register, that completion raises both flags, and that a rising done-sourced interrupt follows a completion. The bench's reference model predicts `sclk`, `mosi` and `irq` on each clock and drives `miso` with noise in the odd halves. Only these scenarios can show the bit order in each mode, the correct received byte, back-to-back starts, dropped writes and pending bytes held by the enable bit.

// File: rtl/spi_bm_pkg.sv
// Shared register addresses and the configuration layout for the SPI byte master.
package spi_bm_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_TX  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RX  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CSR = 2'd2;

    localparam int CFG_W = 4;

    // Configuration bits as they sit in the low nibble of the CSR.
    typedef struct packed {
        logic lsb_first;   // bit 3
        logic cpha;        // bit 2
        logic cpol;        // bit 1
        logic enable;      // bit 0
    } spi_cfg_t;

endpackage

// File: rtl/spi_bm_capture.sv
// One-bit capture stage for serial input.
// Holds the bit sampled on the sampling edge until the shifting edge half a
// bit period later. Assumes sample_en is high for exactly one clock per bit.
module spi_bm_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic din,
    output logic q
);

    // Latch the serial input on the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (sample_en) begin
            q <= din;
        end
    end

endmodule

// File: rtl/spi_bm_shifter.sv
// Bit engine: half-period counter, shift register and serial clock generation.
// One clock cycle is one half bit period. Even halves end with a sampling
// edge and odd halves end with a shifting edge. Assumes the configuration
// inputs are held stable while busy is high.
module spi_bm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         tx_ready,
    input  logic [W-1:0] tx_word,
    input  logic         miso,
    output logic         take,
    output logic         finish,
    output logic [W-1:0] rx_word,
    output logic         busy,
    output logic         mosi,
    output logic         sclk
);

    localparam int HALVES = 2 * W;
    localparam int HW     = $clog2(HALVES);
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

    logic [HW-1:0] half;
    logic [W-1:0]  sh;
    logic          cap_bit;

    // Shift one received bit into the word in the configured order.
    function automatic logic [W-1:0] shift_in(input logic [W-1:0] s,
                                              input logic b,
                                              input logic lsb);
        if (lsb) begin
            shift_in = {b, s[W-1:1]};
        end else begin
            shift_in = {s[W-2:0], b};
        end
    endfunction

    assign finish  = busy && (half == LAST_HALF);
    assign take    = enable && tx_ready && (!busy || finish);
    assign rx_word = shift_in(sh, cap_bit, lsb_first);

    spi_bm_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (busy && !half[0]),
        .din       (miso),
        .q         (cap_bit)
    );

    // Sequence the halves of a byte and move data through the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            half <= '0;
            sh   <= '0;
        end else if (take) begin
            busy <= 1'b1;
            half <= '0;
            sh   <= tx_word;
        end else if (busy) begin
            if (half[0]) begin
                sh <= shift_in(sh, cap_bit, lsb_first);
            end
            if (finish) begin
                busy <= 1'b0;
                half <= '0;
            end else begin
                half <= half + 1'b1;
            end
        end
    end

    // Drive the output data line from the outgoing end of the shifter.
    always_comb begin
        if (!busy) begin
            mosi = 1'b1;
        end else if (lsb_first) begin
            mosi = sh[0];
        end else begin
            mosi = sh[W-1];
        end
    end

    // Gate the divided clock onto the serial clock pin.
    always_comb begin
        if (busy) begin
            sclk = cpol ^ cpha ^ half[0];
        end else begin
            sclk = cpol;
        end
    end

endmodule

// File: rtl/spi_bm_regs.sv
// Host-visible registers: configuration, transmit/receive holding registers
// and status flags with read side effects. Assumes W >= 8 so that the
// status byte fits in the read word.
module spi_bm_regs
    import spi_bm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [W-1:0]      host_wdata,
    input  logic              host_rd,
    output logic [W-1:0]      host_rdata,
    input  logic              take,
    input  logic              finish,
    input  logic [W-1:0]      rx_word,
    input  logic              busy,
    output logic [W-1:0]      tx_word,
    output logic              tx_full,
    output logic              rx_full,
    output logic              done,
    output logic              cfg_enable,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    output logic              cfg_lsb_first
);

    spi_cfg_t     cfg_q;
    logic [W-1:0] rx_buf;
    logic [W-1:0] csr_word;

    logic wr_csr, wr_tx, rd_csr, rd_rx;

    assign wr_csr = host_wr && (host_addr == ADDR_CSR);
    assign wr_tx  = host_wr && (host_addr == ADDR_TX);
    assign rd_csr = host_rd && (host_addr == ADDR_CSR);
    assign rd_rx  = host_rd && (host_addr == ADDR_RX);

    assign cfg_enable    = cfg_q.enable;
    assign cfg_cpol      = cfg_q.cpol;
    assign cfg_cpha      = cfg_q.cpha;
    assign cfg_lsb_first = cfg_q.lsb_first;

    // Hold the configuration nibble written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_csr) begin
            cfg_q <= spi_cfg_t'(host_wdata[CFG_W-1:0]);
        end
    end

    // Accept a byte into the transmit register; drop it when one is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            tx_full <= 1'b0;
        end else if (take) begin
            tx_full <= 1'b0;
        end else if (wr_tx && !tx_full) begin
            tx_word <= host_wdata;
            tx_full <= 1'b1;
        end
    end

    // Capture the completed byte and track the RX-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (finish) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_rx) begin
            rx_full <= 1'b0;
        end
    end

    // Track the done flag, cleared by a CSR read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end else if (rd_csr) begin
            done <= 1'b0;
        end
    end

    // Assemble the status byte for reading.
    always_comb begin
        csr_word      = '0;
        csr_word[7:0] = {busy, done, rx_full, !tx_full, cfg_q};
    end

    // Select the addressed register onto the read bus.
    always_comb begin
        case (host_addr)
            ADDR_RX:  host_rdata = rx_buf;
            ADDR_CSR: host_rdata = csr_word;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_byte_master.sv
// SPI byte master top level. Connects the host register file to the bit
// engine and selects the interrupt source. Assumes a single clock domain;
// the slave select line is left to the surrounding logic.
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              irq_on_done,
    input  logic              miso,
    output logic              mosi,
    output logic              sclk,
    output logic              irq
);

    logic              take, finish, busy;
    logic              tx_full, rx_full, done;
    logic              cfg_enable, cfg_cpol, cfg_cpha, cfg_lsb_first;
    logic [DATA_W-1:0] tx_word, rx_word;

    spi_bm_regs #(.W(DATA_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_wr       (host_wr),
        .host_wdata    (host_wdata),
        .host_rd       (host_rd),
        .host_rdata    (host_rdata),
        .take          (take),
        .finish        (finish),
        .rx_word       (rx_word),
        .busy          (busy),
        .tx_word       (tx_word),
        .tx_full       (tx_full),
        .rx_full       (rx_full),
        .done          (done),
        .cfg_enable    (cfg_enable),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first)
    );

    spi_bm_shifter #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .lsb_first (cfg_lsb_first),
        .tx_ready  (tx_full),
        .tx_word   (tx_word),
        .miso      (miso),
        .take      (take),
        .finish    (finish),
        .rx_word   (rx_word),
        .busy      (busy),
        .mosi      (mosi),
        .sclk      (sclk)
    );

    // Route the selected interrupt source to the pin.
    always_comb begin
        irq = irq_on_done ? done : !tx_full;
    end

endmodule

// File: rtl/spi_bm_checker.sv
// Temporal properties of the SPI byte master, bound to the top level.
module spi_bm_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic take,
    input logic finish,
    input logic tx_full,
    input logic rx_full,
    input logic done,
    input logic enable,
    input logic cpol,
    input logic sclk,
    input logic mosi,
    input logic irq,
    input logic irq_on_done
);

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R2
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(finish)) |-> (sclk != $past(sclk)));

    // R3
    mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mosi);

    // R10
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(enable) && $past(tx_full)));

    // R6
    take_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> tx_full);

    // R7
    rx_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> rx_full);

    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);

    // R9
    irq_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && irq_on_done && $stable(irq_on_done)) |-> $past(finish));

endmodule

bind spi_byte_master spi_bm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .take        (take),
    .finish      (finish),
    .tx_full     (tx_full),
    .rx_full     (rx_full),
    .done        (done),
    .enable      (cfg_enable),
    .cpol        (cfg_cpol),
    .sclk        (sclk),
    .mosi        (mosi),
    .irq         (irq),
    .irq_on_done (irq_on_done)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'd0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       irq_on_done = 1'b0;
    logic       miso = 1'b0;
    logic       mosi, sclk, irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // Behavioural model state.
    bit       m_busy, m_txfull, m_rxfull, m_done, m_fin, m_start;
    int       m_h, xfer_n;
    bit [3:0] m_cfg;
    bit [7:0] m_txbuf, m_cur_tx, m_cur_sl, m_rx;

    spi_byte_master uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rd     (host_rd),
        .host_rdata  (host_rdata),
        .irq_on_done (irq_on_done),
        .miso        (miso),
        .mosi        (mosi),
        .sclk        (sclk),
        .irq         (irq)
    );

    always #10 clk = ~clk;

    function automatic bit [7:0] slave_byte(input int n);
        return 8'h3C ^ 8'(n * 29) ^ 8'(n << 4);
    endfunction

    function automatic int bit_slot(input int h, input bit lsb);
        return lsb ? (h / 2) : (7 - h / 2);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_txfull = 0; m_rxfull = 0; m_done = 0;
            m_h = 0; m_cfg = 0; m_txbuf = 0; m_cur_tx = 0; m_cur_sl = 0; m_rx = 0;
            xfer_n = 0;
        end else begin
            m_fin   = m_busy && (m_h == 15);
            m_start = m_cfg[0] && m_txfull && (!m_busy || m_fin);
            if (host_rd && host_addr == 2'd1) m_rxfull = 0;
            if (host_rd && host_addr == 2'd2) m_done = 0;
            if (m_fin) begin
                m_rx = m_cur_sl; m_rxfull = 1; m_done = 1;
            end
            if (host_wr && host_addr == 2'd2) m_cfg = host_wdata[3:0];
            if (m_start) begin
                m_cur_tx = m_txbuf;
                m_cur_sl = slave_byte(xfer_n);
                xfer_n++;
                m_txfull = 0; m_busy = 1; m_h = 0;
            end else begin
                if (host_wr && host_addr == 2'd0 && !m_txfull) begin
                    m_txbuf = host_wdata; m_txfull = 1;
                end
                if (m_busy) begin
                    if (m_fin) m_busy = 0;
                    else m_h++;
                end
            end
        end
    end

    // Per-cycle comparison and slave data drive on falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            check(sclk == (m_busy ? (m_cfg[1] ^ m_cfg[2] ^ m_h[0]) : m_cfg[1]),
                  "R2 sclk level", sclk, m_busy ? (m_cfg[1] ^ m_cfg[2] ^ m_h[0]) : m_cfg[1]);
            check(irq == (irq_on_done ? m_done : !m_txfull), "R9 irq source", irq,
                  irq_on_done ? m_done : !m_txfull);
            if (!m_busy) begin
                check(mosi == 1'b1, "R3 mosi idle", mosi, 1);
            end else if (m_h % 2 == 0) begin
                check(mosi == m_cur_tx[bit_slot(m_h, m_cfg[3])], "R4 mosi bit order",
                      mosi, m_cur_tx[bit_slot(m_h, m_cfg[3])]);
            end
        end
        if (m_busy && (m_h % 2 == 0)) miso = m_cur_sl[bit_slot(m_h, m_cfg[3])];
        else miso = ~miso;
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic host_write(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic read_csr(input string tag);
        bit [7:0] exp;
        @(negedge clk);
        host_rd = 1; host_addr = 2'd2;
        exp = {m_busy, m_done, m_rxfull, !m_txfull, m_cfg};
        #1 check(host_rdata == exp, tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic read_rx(input bit [7:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1; host_addr = 2'd1;
        #1 check(host_rdata == exp, tag, host_rdata, exp);
        check(host_rdata == m_rx, tag, host_rdata, m_rx);
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || (m_txfull && m_cfg[0]));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs held in reset
        check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        check(mosi == 1'b1, "R1 mosi in reset", mosi, 1);
        check(irq == 1'b1, "R1 irq in reset", irq, 1);
        rst_n = 1;
        read_csr("R1 R11 reset status");
        check(host_rdata == 8'h10, "R1 status 0x10", host_rdata, 8'h10);

        // R2 R3 R4 R5: every mode in both bit orders
        for (int mode = 0; mode < 4; mode++) begin
            for (int lsb = 0; lsb < 2; lsb++) begin
                host_write(2'd2, {4'd0, lsb[0], mode[1], mode[0], 1'b1});
                host_write(2'd0, 8'h96 ^ 8'(mode * 37 + lsb * 11));
                wait_idle();
                read_csr("R11 R7 R8 status after byte");
                read_rx(slave_byte(xfer_n - 1), "R5 received byte");
                read_csr("R7 R8 flags cleared");
                check(!m_done && !m_rxfull, "R8 model flags", m_done, 0);
            end
        end

        // R11: unused address reads zero
        @(negedge clk);
        host_addr = 2'd3;
        #1 check(host_rdata == 8'h00, "R11 address 3", host_rdata, 0);

        // R6: back-to-back, third write dropped while TX full
        host_write(2'd2, 8'h01);
        host_write(2'd0, 8'hC3);
        host_write(2'd0, 8'h5A);
        host_write(2'd0, 8'hFF);
        read_csr("R6 status while queued");
        wait_idle();
        check(xfer_n == 10, "R6 only two bytes sent", xfer_n, 10);
        read_rx(slave_byte(9), "R6 second byte received");
        read_csr("R6 R11 idle after pair");

        // R7: RX-full survives until RX read
        host_write(2'd0, 8'h21);
        wait_idle();
        read_csr("R7 RX full set");
        read_rx(slave_byte(10), "R7 RX read");
        read_csr("R7 RX full clear");

        // R9: interrupt follows done
        irq_on_done = 1;
        @(negedge clk);
        #1 check(irq == 1'b0, "R9 irq low before done", irq, 0);
        host_write(2'd0, 8'h7E);
        wait_idle();
        @(negedge clk);
        #1 check(irq == 1'b1, "R9 irq on done", irq, 1);
        read_csr("R8 done read");
        @(negedge clk);
        #1 check(irq == 1'b0, "R9 irq cleared by CSR read", irq, 0);
        irq_on_done = 0;

        // R10: disabled block holds the byte
        host_write(2'd2, 8'h00);
        host_write(2'd0, 8'hA7);
        repeat (40) @(negedge clk);
        check(sclk == 1'b0 && !m_busy, "R10 no transfer when disabled", sclk, 0);
        read_csr("R10 byte pending, not busy");
        host_write(2'd2, 8'h0B);
        wait_idle();
        read_rx(slave_byte(12), "R10 byte sent after enable");

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule